// File: doc/BRIEF.md
# Subranging Converter Frame Sequencer

This block paces a two-pass subranging converter from a single master clock. Each conversion frame lasts a fixed number of master clocks (36 by default). An active-low encode pulse from the user fixes where each frame starts. Every control event is decoded from a frame counter that the encode falling edge reloads:

- the track/hold switch;
- the coarse-pass strobe;
- the residue-pass strobe;
- the correction strobe;
- the output register load.

Once the first encode has arrived, the frame keeps running on its own. Track is therefore restored every frame without further input.

The corrected 14-bit word comes from logic outside this block on `word_in`. That input has no valid/ready handshake and no back-pressure. The block samples it once per frame, on the last count of the frame, so the producer must hold a settled word at that edge. The sampled word is shown on the outputs one full frame after its encode. It is split into a 6-bit upper group and an 8-bit lower group, each with its own active-low drive enable.

Encode pulses that arrive off the frame boundary, or that stay low longer than one clock, raise a sticky error flag. The block still realigns to the new edge.

Top module: `subrange_seq`

## Requirements
- R1: After reset the block is idle. In that state `th_track` is 1, all three strobes are 0, `sync_error` is 0 and the output register holds 0. The counter does not advance until an encode falling edge is seen.
- R2: An encode falling edge is a clock edge at which `enc_n` is sampled 0 after a previous sample of 1. That edge sets the frame count to 1. The count then advances by one per clock and wraps from 36 back to 1.
- R3: While running, `th_track` is 1 for counts 22 through 34 and 0 for counts 35, 36 and 1 through 21.
- R4: While running, `coarse_go` is 1 only at count 2, `resid_go` only at count 10 and `corr_go` only at count 18. Each lasts one cycle per frame, and at most one of the three is high in any cycle.
- R5: The output register loads `word_in` on the clock edge that ends count 36, so the new word is visible during count 1 of the next frame. All 14 bits change in that one cycle, and the register holds its value in every other cycle.
- R6: With `twos_comp` = 0 the word is stored unchanged (offset binary). With `twos_comp` = 1 bit 13 is inverted as it is stored (two's complement).
- R7: `hi_oe_n` = 0 drives register bits 13:8 onto `dout[13:8]`, and `lo_oe_n` = 0 drives bits 7:0 onto `dout[7:0]`. Each group is high impedance while its enable is 1, and the two groups are independent of each other.
- R8: A falling edge seen while running at any count other than 36 sets `sync_error`, which stays 1 until reset. The count still restarts at 1 on that edge.
- R9: `enc_n` sampled 0 on two consecutive clock edges sets `sync_error`.
- R10: Without further encode pulses a running frame keeps wrapping, still loading the register and returning to track each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_n | input | 1 | Active-low encode pulse, synchronous to clk |
| twos_comp | input | 1 | Static coding select: 1 = two's complement, 0 = offset binary |
| word_in | input | 14 | Corrected conversion result, sampled at count 36 |
| hi_oe_n | input | 1 | Active-low drive enable for dout[13:8] |
| lo_oe_n | input | 1 | Active-low drive enable for dout[7:0] |
| th_track | output | 1 | Track/hold control: 1 = track, 0 = hold |
| coarse_go | output | 1 | Single-cycle coarse-pass start strobe |
| resid_go | output | 1 | Single-cycle residue-pass start strobe |
| corr_go | output | 1 | Single-cycle correction strobe |
| sync_error | output | 1 | Sticky flag for a misaligned or over-long encode |
| dout | output | 14 | Three-state output word, two separately enabled groups |

## Verification
The bench builds the block with its default values: a 36-clock frame, the track and hold switches at counts 22 and 35, the strobes at counts 2, 10 and 18, and a 6/8 split of the 14-bit word. With a 36-clock frame, several complete frames fit in a few hundred cycles. Those frames exercise encode-aligned starts, free-running wraps, both output codings, each enable group on its own, and both kinds of encode fault, each followed by realignment.

// File: rtl/subrange_pkg.sv
package subrange_pkg;
  typedef struct packed {
    logic coarse;
    logic resid;
    logic corr;
  } pass_strobe_t;
endpackage

// File: rtl/enc_edge.sv
module enc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic enc_n,
  input  logic running,
  input  logic at_end,
  output logic fall,
  output logic sync_error
);
  logic enc_q;
  logic bad;

  assign fall = enc_q & ~enc_n;
  // misaligned edge, or pulse held low on two samples
  assign bad  = (fall & running & ~at_end) | (~enc_n & ~enc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_q      <= 1'b1;
      sync_error <= 1'b0;
    end else begin
      enc_q <= enc_n;
      if (bad) sync_error <= 1'b1;
    end
  end

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_error |=> sync_error);
  // R9
  long_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enc_n && !enc_q) |=> sync_error);
endmodule

// File: rtl/frame_ctr.sv
module frame_ctr #(
  parameter int FRAME = 36,
  localparam int CW = $clog2(FRAME + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall,
  output logic [CW-1:0] cnt,
  output logic          running
);
  localparam logic [CW-1:0] LAST = CW'(FRAME);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (fall) begin
      cnt     <= CW'(1);
      running <= 1'b1;
    end else if (running) begin
      cnt <= (cnt == LAST) ? CW'(1) : cnt + CW'(1);
    end
  end

  // R2
  realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> (cnt == CW'(1)));
  // R2
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !fall && cnt == LAST) |=> (cnt == CW'(1)));
  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !fall && cnt != LAST) |=> (cnt == $past(cnt) + CW'(1)));
  // R1
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !fall) |=> (cnt == '0));
endmodule

// File: rtl/out_port.sv
module out_port #(
  parameter int W    = 14,
  parameter int HI_W = 6,
  localparam int LO_W = W - HI_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         twos,
  input  logic [W-1:0] word_in,
  input  logic         hi_oe_n,
  input  logic         lo_oe_n,
  output logic [W-1:0] dout
);
  logic [W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= {word_in[W-1] ^ twos, word_in[W-2:0]};
  end

  assign dout[W-1:LO_W] = hi_oe_n ? {HI_W{1'bz}} : q[W-1:LO_W];
  assign dout[LO_W-1:0] = lo_oe_n ? {LO_W{1'bz}} : q[LO_W-1:0];

  // R5
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
  // R6
  coding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q[W-1] == ($past(word_in[W-1]) ^ $past(twos))));
endmodule

// File: rtl/subrange_seq.sv
module subrange_seq #(
  parameter int FRAME    = 36,
  parameter int TRACK_AT = 22,
  parameter int HOLD_AT  = 35,
  parameter int COARSE_AT = 2,
  parameter int RESID_AT  = 10,
  parameter int CORR_AT   = 18,
  parameter int W        = 14,
  parameter int HI_W     = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enc_n,
  input  logic         twos_comp,
  input  logic [W-1:0] word_in,
  input  logic         hi_oe_n,
  input  logic         lo_oe_n,
  output logic         th_track,
  output logic         coarse_go,
  output logic         resid_go,
  output logic         corr_go,
  output logic         sync_error,
  output logic [W-1:0] dout
);
  import subrange_pkg::*;
  localparam int CW = $clog2(FRAME + 1);

  logic          fall;
  logic          running;
  logic [CW-1:0] cnt;
  logic          at_end;
  pass_strobe_t  stb;

  assign at_end = (cnt == CW'(FRAME));

  enc_edge u_edge (
    .clk(clk), .rst_n(rst_n), .enc_n(enc_n), .running(running),
    .at_end(at_end), .fall(fall), .sync_error(sync_error)
  );

  frame_ctr #(.FRAME(FRAME)) u_ctr (
    .clk(clk), .rst_n(rst_n), .fall(fall), .cnt(cnt), .running(running)
  );

  out_port #(.W(W), .HI_W(HI_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(running & at_end), .twos(twos_comp),
    .word_in(word_in), .hi_oe_n(hi_oe_n), .lo_oe_n(lo_oe_n), .dout(dout)
  );

  assign th_track = ~running | ((cnt >= CW'(TRACK_AT)) && (cnt < CW'(HOLD_AT)));
  assign stb.coarse = running & (cnt == CW'(COARSE_AT));
  assign stb.resid  = running & (cnt == CW'(RESID_AT));
  assign stb.corr   = running & (cnt == CW'(CORR_AT));
  assign coarse_go  = stb.coarse;
  assign resid_go   = stb.resid;
  assign corr_go    = stb.corr;

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({coarse_go, resid_go, corr_go}));
  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coarse_go && !fall) |=> !coarse_go);
  // R3
  hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !fall && cnt == CW'(HOLD_AT - 1)) |=> !th_track);
  // R1
  idle_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> th_track);
endmodule

// File: tb/tb_subrange_seq.sv
module tb_subrange_seq;
  localparam int FR = 36;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_n = 1'b1;
  logic        twos_comp = 1'b0;
  logic [13:0] word_in = '0;
  logic        hi_oe_n = 1'b0;
  logic        lo_oe_n = 1'b0;
  logic        th_track, coarse_go, resid_go, corr_go, sync_error;
  logic [13:0] dout;

  subrange_seq dut (
    .clk(clk), .rst_n(rst_n), .enc_n(enc_n), .twos_comp(twos_comp),
    .word_in(word_in), .hi_oe_n(hi_oe_n), .lo_oe_n(lo_oe_n),
    .th_track(th_track), .coarse_go(coarse_go), .resid_go(resid_go),
    .corr_go(corr_go), .sync_error(sync_error), .dout(dout)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // behavioural reference state
  int          m_cnt = 0;
  bit          m_run = 0;
  bit          m_encq = 1;
  bit          m_err = 0;
  logic [13:0] m_q = '0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cycles, act, exp);
    end
  endtask

  task automatic compare();
    bit exp_track;
    exp_track = !m_run || (m_cnt >= 22 && m_cnt < 35);
    check(th_track == exp_track, "R3 track", th_track, exp_track);
    check(coarse_go == (m_run && m_cnt == 2), "R4 coarse", coarse_go, m_run && m_cnt == 2);
    check(resid_go == (m_run && m_cnt == 10), "R4 resid", resid_go, m_run && m_cnt == 10);
    check(corr_go == (m_run && m_cnt == 18), "R4 corr", corr_go, m_run && m_cnt == 18);
    check(sync_error == m_err, "R8/R9 sync_error", sync_error, m_err);
    if (!hi_oe_n) check(dout[13:8] == m_q[13:8], "R7 upper group", dout[13:8], m_q[13:8]);
    if (!lo_oe_n) check(dout[7:0] == m_q[7:0], "R7 lower group", dout[7:0], m_q[7:0]);
  endtask

  // one clock: drive encode, advance model as the edge does, compare
  task automatic tick(input bit e);
    bit fall;
    enc_n = e;
    @(posedge clk);
    #1;
    cycles++;
    fall = (e == 0) && m_encq;
    if ((fall && m_run && m_cnt != FR) || (e == 0 && m_encq == 0)) m_err = 1;
    if (m_run && m_cnt == FR) m_q = {word_in[13] ^ twos_comp, word_in[12:0]};
    if (fall) begin
      m_cnt = 1;
      m_run = 1;
    end else if (m_run) begin
      m_cnt = (m_cnt == FR) ? 1 : m_cnt + 1;
    end
    m_encq = e;
    compare();
  endtask

  // run n frames; with_enc gives an encode at every boundary (R10 when 0)
  task automatic frames(input int n, input bit with_enc, input logic [13:0] w0);
    for (int f = 0; f < n; f++) begin
      word_in = w0 + 14'(f * 14'h0515);
      for (int k = 0; k < FR; k++) tick(!(with_enc && m_run && m_cnt == FR));
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    enc_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
    m_cnt = 0; m_run = 0; m_encq = 1; m_err = 0; m_q = '0;
    compare();
    // R1 explicit reset state
    check(th_track == 1'b1, "R1 reset track", th_track, 1);
    check(dout == 14'h0, "R1 reset register", dout, 0);
    check(sync_error == 1'b0, "R1 reset error", sync_error, 0);
  endtask

  initial begin
    do_reset();
    word_in = 14'h2AB3;
    repeat (6) tick(1);                 // R1 idle without encode
    tick(0); tick(1);                   // R2 first encode
    frames(2, 1, 14'h1234);             // R2 R3 R4 R5 aligned frames
    check(dout == 14'h1234 + 14'h0515, "R5 word latency", dout, 14'h1234 + 14'h0515);
    twos_comp = 1'b1;
    frames(1, 1, 14'h3C01);             // R6 two's complement
    check(dout == 14'h1C01, "R6 msb inverted", dout, 14'h1C01);
    twos_comp = 1'b0;
    hi_oe_n = 1'b1;
    frames(1, 1, 14'h0F0F);             // R7 lower group alone
    hi_oe_n = 1'b0; lo_oe_n = 1'b1;
    frames(1, 1, 14'h3FFF);             // R7 upper group alone
    lo_oe_n = 1'b0;
    frames(2, 0, 14'h2001);             // R10 free running
    check(sync_error == 1'b0, "R10 no error", sync_error, 0);
    for (int k = 0; k < 10; k++) tick(1);
    tick(0); tick(1);                   // R8 misaligned encode
    check(sync_error == 1'b1, "R8 misaligned flag", sync_error, 1);
    frames(1, 1, 14'h0ABC);
    do_reset();
    tick(0); tick(1);
    frames(1, 1, 14'h1111);
    for (int k = 0; k < 40 && m_cnt != FR; k++) tick(1);
    tick(0); tick(0); tick(1);          // R9 over-long encode
    check(sync_error == 1'b1, "R9 long pulse flag", sync_error, 1);
    frames(1, 1, 14'h2222);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule